// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Voting

This block receives asynchronous serial characters on a single input line. A falling edge on the idle line opens a frame. A programmable prescaler then produces sample ticks at 16 times the bit rate, or 8 times in the double-speed setting. Three samples around the centre of every bit are combined by majority vote. This applies to the start bit, the data bits, the parity bit and the stop bit alike. A start bit that votes high is treated as noise, and the receiver goes back to waiting.

Each completed character holds 5 to 9 data bits. It is placed in a one-deep holding register together with its own framing and parity error flags, and it stays there until the consumer pulses the read strobe. A character that completes while the register is still occupied is discarded, and an overrun flag is raised. The flow-control output tells the remote sender to pause whenever the register holds an unread character.

Top module: `uart_rx_vote`

## Requirements
- R1: After reset the receiver waits for a high-to-low transition on `rxd`. If the start bit then votes 1, nothing is delivered and the receiver returns to waiting for the next falling edge.
- R2: `data_len` gives the number of data bits as code+5 for codes 0 to 4; codes 5 to 7 select 9 bits. Data arrives least-significant bit first. `rx_data` bits at and above the selected length read 0.
- R3: Each bit takes the majority of three samples: samples 8, 9 and 10 of the 16 in normal mode, and samples 4, 5 and 6 of the 8 when `dbl_speed`=1. A disturbance lasting one sample tick does not change the received bit.
- R4: One bit lasts OSR*(`baud_div`+1) clock cycles, where OSR is 16 when `dbl_speed`=0 and 8 when `dbl_speed`=1. The prescaler restarts on the start edge.
- R5: `par_mode`=2'b10 expects even parity, 2'b11 expects odd parity, and 2'b0x means no parity bit is present. On a mismatch `par_err` is set together with the character. With parity disabled, `par_err` is 0.
- R6: The stop bit is voted like every other bit. If it votes 0, `frm_err` is set together with that character.
- R7: A completed character sets `rx_full`, and `rx_data`, `frm_err` and `par_err` then hold steady until a one-cycle `rd_take`. That strobe clears `rx_full`.
- R8: If a character completes while `rx_full`=1, the new character is dropped and `ovr_flag` is set. `ovr_flag` is cleared by `rd_take`.
- R9: `rts_o` is 1 (sender may transmit) while the holding register is empty, and 0 while it holds an unread character.
- R10: After reset, `rx_full`, `ovr_flag`, `frm_err` and `par_err` are 0 and `rts_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| baud_div | input | DIV_W | Prescaler divisor; tick period is divisor+1 clocks |
| dbl_speed | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| data_len | input | 3 | Data bit count minus 5 (5 to 7 mean 9 bits) |
| par_mode | input | 2 | 0x none, 10 even, 11 odd |
| rd_take | input | 1 | One-cycle read strobe that empties the holding register |
| rx_data | output | 9 | Received data, right-aligned |
| rx_full | output | 1 | Holding register contains an unread character |
| frm_err | output | 1 | Stop bit of the held character voted 0 |
| par_err | output | 1 | Parity mismatch on the held character |
| ovr_flag | output | 1 | A character was dropped because the register was full |
| rts_o | output | 1 | Flow control: 1 allows the sender to transmit |

## Verification
The properties assume that `baud_div`, `dbl_speed`, `data_len` and `par_mode` do not change while a frame is in flight, and that `rd_take` is a single-cycle pulse. The parity property depends on the first of these, because it relates the parity setting to the moment `rx_full` rises. The bench follows these rules: it changes the configuration only while the line is idle and the holding register has been emptied, and it always drives the read strobe for exactly one clock.

// File: rtl/urx_pkg.sv
// Shared types for the oversampling receiver.
// Assumes at most 9 data bits per character.
package urx_pkg;
    localparam int DATA_MAX = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                frm;
        logic                par;
    } rx_char_t;
endpackage

// File: rtl/urx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Resets to the idle (high) level so that no false start edge appears.
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // one stage of the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 1'b1;
                else if (g == 0)
                    chain[g] <= din;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_baud_tick.sv
// Oversampling prescaler: one tick every div+1 clocks.
// A restart reloads the count so that the sample phase aligns with the start edge.
module urx_baud_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // down-counter with reload at zero or on restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || cnt == '0)
            cnt <= div;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0) && !restart;
endmodule

// File: rtl/urx_frame_fsm.sv
// Frame sequencer: detects the start edge, counts sample ticks, votes three
// centre samples per bit, and assembles data, parity and stop results.
// Assumes that the format inputs are stable during a frame and that rx_s is synchronous.
module urx_frame_fsm
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_s,
    input  logic       tick,
    input  logic       dbl_speed,
    input  logic [2:0] data_len,
    input  logic [1:0] par_mode,
    output logic       restart,
    output logic       done,
    output rx_char_t   char_o
);
    localparam int CW = 5;

    rx_state_t           state;
    logic [CW-1:0]       cnt, cnt_n, osr, v1, v2, v3;
    logic [3:0]          idx, nbits;
    logic [DATA_MAX-1:0] shreg;
    logic [1:0]          vote_q;
    logic                maj, par_acc, par_bad, frm_q, rx_prev;

    // per-mode sample positions, data length decode and the vote
    always_comb begin
        osr   = dbl_speed ? CW'(8) : CW'(16);
        v1    = osr >> 1;
        v2    = v1 + CW'(1);
        v3    = v1 + CW'(2);
        cnt_n = cnt + CW'(1);
        nbits = (data_len > 3'd4) ? 4'd9 : ({1'b0, data_len} + 4'd5);
        maj   = (vote_q[0] & vote_q[1]) | (vote_q[0] & rx_s) | (vote_q[1] & rx_s);
    end

    assign restart = (state == ST_IDLE) && rx_prev && !rx_s;

    // frame sequencing, sample counting and bit decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            vote_q  <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            frm_q   <= 1'b0;
            rx_prev <= 1'b1;
            done    <= 1'b0;
        end else begin
            rx_prev <= rx_s;
            done    <= 1'b0;
            if (state == ST_IDLE) begin
                cnt     <= '0;
                idx     <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                par_bad <= 1'b0;
                if (restart)
                    state <= ST_START;
            end else if (tick) begin
                cnt <= cnt_n;
                if (cnt_n == v1) vote_q[0] <= rx_s;
                if (cnt_n == v2) vote_q[1] <= rx_s;
                if (cnt_n == v3) begin
                    case (state)
                        ST_START: if (maj) state <= ST_IDLE;
                        ST_DATA: begin
                            shreg[idx] <= maj;
                            par_acc    <= par_acc ^ maj;
                        end
                        ST_PAR:   par_bad <= par_acc ^ maj ^ par_mode[0];
                        ST_STOP: begin
                            frm_q <= ~maj;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (cnt_n == osr) begin
                    cnt <= '0;
                    case (state)
                        ST_START: state <= ST_DATA;
                        ST_DATA:
                            if (idx == nbits - 4'd1)
                                state <= par_mode[1] ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 4'd1;
                        ST_PAR:   state <= ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign char_o.data = shreg;
    assign char_o.frm  = frm_q;
    assign char_o.par  = par_bad & par_mode[1];
endmodule

// File: rtl/urx_hold_buf.sv
// One-deep holding register with overrun detection and flow control.
// A read in the same cycle as a new character frees the slot first.
module urx_hold_buf
    import urx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  rx_char_t            char_i,
    input  logic                rd_take,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                frm_err,
    output logic                par_err,
    output logic                full,
    output logic                ovr,
    output logic                rts
);
    rx_char_t hold;

    // capture, release and overrun tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (rd_take) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
            if (load) begin
                if (!full || rd_take) begin
                    hold <= char_i;
                    full <= 1'b1;
                end else begin
                    ovr <= 1'b1;
                end
            end
        end
    end

    assign rx_data = hold.data;
    assign frm_err = hold.frm;
    assign par_err = hold.par;
    assign rts     = ~full;
endmodule

// File: rtl/uart_rx_vote.sv
// Top of the oversampling receiver: synchronizer, prescaler, frame sequencer
// and holding register. Assumes configuration changes only while idle.
module uart_rx_vote
    import urx_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             dbl_speed,
    input  logic [2:0]       data_len,
    input  logic [1:0]       par_mode,
    input  logic             rd_take,
    output logic [8:0]       rx_data,
    output logic             rx_full,
    output logic             frm_err,
    output logic             par_err,
    output logic             ovr_flag,
    output logic             rts_o
);
    logic     rx_s, restart, tick, done;
    rx_char_t ch;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    urx_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(baud_div), .tick(tick)
    );

    urx_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(tick),
        .dbl_speed(dbl_speed), .data_len(data_len), .par_mode(par_mode),
        .restart(restart), .done(done), .char_o(ch)
    );

    urx_hold_buf u_buf (
        .clk(clk), .rst_n(rst_n), .load(done), .char_i(ch), .rd_take(rd_take),
        .rx_data(rx_data), .frm_err(frm_err), .par_err(par_err),
        .full(rx_full), .ovr(ovr_flag), .rts(rts_o)
    );
endmodule

// File: rtl/urx_props.sv
// Port-level properties of the receiver, bound to the top module.
// Assumes single-cycle read strobes and a configuration held steady per frame.
module urx_props (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_take,
    input logic       rx_full,
    input logic       ovr_flag,
    input logic [8:0] rx_data,
    input logic       par_err,
    input logic [1:0] par_mode
);
    // R8: overrun can only be flagged while a character is held
    a_r8_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |-> !ovr_flag);

    // R8: a read clears the overrun flag
    a_r8_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && rd_take |=> !ovr_flag);

    // R7: the held character persists until it is read
    a_r7_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !rd_take |=> rx_full && $stable(rx_data));

    // R7: the register only empties after a read strobe
    a_r7_fall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_take));

    // R5: no parity error when parity is disabled
    a_r5_no_par_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) && !par_mode[1] |-> !par_err);
endmodule

bind uart_rx_vote urx_props u_props (
    .clk(clk), .rst_n(rst_n), .rd_take(rd_take), .rx_full(rx_full),
    .ovr_flag(ovr_flag), .rx_data(rx_data), .par_err(par_err), .par_mode(par_mode)
);

// File: tb/test_uart_rx_vote.sv
module test_uart_rx_vote;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [11:0] baud_div = 12'd1;
    logic        dbl_speed = 1'b0;
    logic [2:0]  data_len = 3'd3;
    logic [1:0]  par_mode = 2'b00;
    logic        rd_take = 1'b0;
    logic [8:0]  rx_data;
    logic        rx_full, frm_err, par_err, ovr_flag, rts_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_vote i_uart_rx_vote (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
        .dbl_speed(dbl_speed), .data_len(data_len), .par_mode(par_mode),
        .rd_take(rd_take), .rx_data(rx_data), .rx_full(rx_full),
        .frm_err(frm_err), .par_err(par_err), .ovr_flag(ovr_flag), .rts_o(rts_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bit_period();
        return (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
    endfunction

    task automatic hold_line(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // one bit; optionally flip the line for one tick near the bit centre
    task automatic drive_bit(input logic v, input bit glitch);
        int bp = bit_period();
        int p  = int'(baud_div) + 1;
        if (!glitch) begin
            hold_line(v, bp);
        end else begin
            hold_line(v, bp / 2);
            hold_line(~v, p);
            hold_line(v, bp - bp / 2 - p);
        end
    endtask

    task automatic send(input logic [8:0] d, input int len, input bit bpar,
                        input bit bstop, input int glitch_bit);
        logic p;
        p = 1'b0;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < len; i++) begin
            drive_bit(d[i], glitch_bit == i);
            p = p ^ d[i];
        end
        if (par_mode[1])
            drive_bit(p ^ par_mode[0] ^ bpar, 1'b0);
        drive_bit(~bstop, 1'b0);
        hold_line(1'b1, 2 * bit_period());
    endtask

    task automatic take();
        rd_take = 1'b1;
        @(negedge clk);
        rd_take = 1'b0;
        @(negedge clk);
    endtask

    // full frame with expected results and release of the buffer
    task automatic frame_check(input logic [8:0] d, input int len, input bit bpar,
                               input bit bstop, input int glitch_bit, input string tag);
        logic [8:0] mask;
        mask = 9'((1 << len) - 1);
        send(d, len, bpar, bstop, glitch_bit);
        chk({tag, " R7 full"}, int'(rx_full), 1);
        chk({tag, " R2 data"}, int'(rx_data), int'(d & mask));
        chk({tag, " R6 frm"}, int'(frm_err), int'(bstop));
        chk({tag, " R5 par"}, int'(par_err), int'(bpar && par_mode[1]));
        chk({tag, " R9 rts busy"}, int'(rts_o), 0);
        take();
        chk({tag, " R7 empty"}, int'(rx_full), 0);
        chk({tag, " R9 rts free"}, int'(rts_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 full", int'(rx_full), 0);
        chk("R10 ovr", int'(ovr_flag), 0);
        chk("R10 frm", int'(frm_err), 0);
        chk("R10 par", int'(par_err), 0);
        chk("R10 rts", int'(rts_o), 1);
        hold_line(1'b1, 40);

        // R2 R4 R5 R6: sweep of speed, length, parity and error patterns
        for (int dbl = 0; dbl < 2; dbl++) begin
            for (int len = 5; len <= 9; len++) begin
                for (int pmi = 0; pmi < 3; pmi++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [8:0] d;
                        dbl_speed = dbl[0];
                        data_len  = 3'(len - 5);
                        par_mode  = (pmi == 0) ? 2'b00 : (pmi == 1) ? 2'b10 : 2'b11;
                        d = 9'((k * 109 + len * 37 + pmi * 11 + dbl * 5) & 511);
                        frame_check(d, len, (k == 2), (k == 3), -1, "sweep");
                    end
                end
            end
        end

        // R2: length codes above 4 select 9 bits
        dbl_speed = 1'b0; par_mode = 2'b00; data_len = 3'd7;
        frame_check(9'h1A5, 9, 1'b0, 1'b0, -1, "R2 code7");

        // R4: a slower divisor in both modes
        baud_div = 12'd3; data_len = 3'd3;
        frame_check(9'h0C3, 8, 1'b0, 1'b0, -1, "R4 div3 x16");
        dbl_speed = 1'b1;
        frame_check(9'h03C, 8, 1'b0, 1'b0, -1, "R4 div3 x8");

        // R3: one-tick disturbance at a bit centre is outvoted
        for (int dbl = 0; dbl < 2; dbl++) begin
            for (int b = 0; b < 8; b++) begin
                dbl_speed = dbl[0];
                par_mode  = 2'b10;
                frame_check(9'((b * 53 + 17) & 255), 8, 1'b0, 1'b0, b, "R3 vote");
            end
        end

        // R1: short low pulse before the first vote sample is ignored
        dbl_speed = 1'b0; par_mode = 2'b00;
        hold_line(1'b0, 3 * (int'(baud_div) + 1));
        hold_line(1'b1, 12 * bit_period());
        chk("R1 glitch no char", int'(rx_full), 0);
        chk("R1 glitch rts", int'(rts_o), 1);
        frame_check(9'h05A, 8, 1'b0, 1'b0, -1, "R1 after glitch");

        // R8: second character while full is dropped
        send(9'h011, 8, 1'b0, 1'b0, -1);
        chk("R8 no ovr yet", int'(ovr_flag), 0);
        send(9'h0EE, 8, 1'b0, 1'b0, -1);
        chk("R8 ovr set", int'(ovr_flag), 1);
        chk("R8 first kept", int'(rx_data), 32'h011);
        chk("R9 rts while full", int'(rts_o), 0);
        take();
        chk("R8 ovr cleared", int'(ovr_flag), 0);
        chk("R8 empty", int'(rx_full), 0);
        frame_check(9'h0EF, 8, 1'b0, 1'b0, -1, "R8 after ovr");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule